// File: doc/BRIEF.md
# Receive Data Latch for DMA Transfers

This block sits between a parallel peripheral bus and a DMA controller. On the receive path of a DMA transfer, it captures the byte that is present on the bus data lines and holds it until the DMA controller reads it. A role input selects which handshake line marks a valid byte. When the block acts as the target, the byte is taken on the acknowledge line. When it acts as the initiator, the byte is taken on the request line.

Both handshake lines arrive from outside the block's clock. Each one passes through a synchronizer, and capture happens on the rising edge of the synchronized signal, so one handshake produces exactly one load. Nothing is loaded unless the DMA mode input is high. When parity checking is enabled, the byte and its parity line are checked for odd parity at the moment of load. A mismatch raises a one-cycle error pulse that the status logic can count. The DMA controller reads the latched byte by asserting its read strobe and its acknowledge together. At all other times the read bus is zero.

Top module: `rx_dma_latch`

## Requirements
- R1: After reset, the latched byte is 0x00 and no parity error pulse is issued.
- R2: In the target role (role_tgt_i=1) with DMA mode on, a rising edge on ack_i loads bus_data_i, and edges on req_i load nothing.
- R3: In the initiator role (role_tgt_i=0) with DMA mode on, a rising edge on req_i loads bus_data_i, and edges on ack_i load nothing.
- R4: While dma_mode_i is low at the time of the synchronized edge, the latched byte does not change.
- R5: One rising handshake edge causes exactly one load. Changes on bus_data_i while the strobe stays high are not captured.
- R6: rd_data_o carries the latched byte while rd_strobe_i and dma_ack_i are both 1, and is 0x00 otherwise.
- R7: Parity is odd over the 9 bits made of bus_data_i and bus_par_i. If par_en_i=1 at load and the count of ones across those 9 bits is even, parity_err_o is high for exactly one cycle.
- R8: parity_err_o stays low when par_en_i=0, when the parity is correct, and when no load takes place.
- R9: A strobe that rises before clock edge k updates the latched byte at edge k+2, not earlier.
- R10: Changing role_tgt_i while a handshake line is already high causes no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_data_i | input | 8 | Bus data lines (true polarity) |
| bus_par_i | input | 1 | Bus parity line (odd parity) |
| req_i | input | 1 | Bus request handshake, asynchronous, active high |
| ack_i | input | 1 | Bus acknowledge handshake, asynchronous, active high |
| role_tgt_i | input | 1 | 1 = target (loads on ack), 0 = initiator (loads on req) |
| dma_mode_i | input | 1 | Enables loading |
| par_en_i | input | 1 | Enables the parity check at load |
| dma_ack_i | input | 1 | DMA acknowledge from the controller |
| rd_strobe_i | input | 1 | Read strobe from the controller |
| rd_data_o | output | 8 | Latched byte, gated by the read qualifiers |
| parity_err_o | output | 1 | One-cycle parity error pulse |

## Verification
Random handshakes vary four things: the role, which line is pulsed, DMA mode, and parity enable, with good or corrupted parity. A mismatch in any of these separates a correct role select and mode gate from a design that loads on the wrong line or ignores the mode. Directed cases cover the rest. Sampling the bus one cycle early and on time pins the two-stage latency. Changing the data while the strobe is held high distinguishes edge capture from level capture. Switching the role while a line is high catches a design that selects the line before detecting the edge. Driving one read qualifier at a time checks the gating of the read bus.

// File: rtl/rx_latch_pkg.sv
package rx_latch_pkg;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    ROLE_INIT = 1'b0,
    ROLE_TGT  = 1'b1
  } role_e;

  typedef struct packed {
    logic              par;
    logic [DATA_W-1:0] data;
  } bus_word_t;
endpackage

// File: rtl/hs_edge_sync.sv
module hs_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise_o = sync_q[LAST] & ~prev_q;

  // R5
  rise_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/rx_capture.sv
module rx_capture
  import rx_latch_pkg::*;
#(
  parameter int unsigned W       = DATA_W,
  parameter bit          ODD_PAR = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         par_en_i,
  input  logic [W-1:0] data_i,
  input  logic         par_i,
  output logic [W-1:0] data_o,
  output logic         err_o
);
  logic [W:0]   word;
  logic         ones_odd;
  logic         bad_par;
  logic [W-1:0] data_q;
  logic         err_q;

  assign word = {par_i, data_i};

  // xor chain across data and parity
  logic [W:0] chain;
  assign chain[0] = word[0];
  for (genvar i = 1; i <= W; i++) begin : g_chain
    assign chain[i] = chain[i-1] ^ word[i];
  end
  assign ones_odd = chain[W];

  if (ODD_PAR) begin : g_odd
    assign bad_par = ~ones_odd;
  end else begin : g_even
    assign bad_par = ones_odd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= load_i & par_en_i & bad_par;
      if (load_i) data_q <= data_i;
    end
  end

  assign data_o = data_q;
  assign err_o  = err_q;

  // R4
  hold_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(data_o));
  // R8
  err_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(par_en_i));
endmodule

// File: rtl/rd_port.sv
module rd_port #(
  parameter int unsigned W = 8
) (
  input  logic         rd_strobe_i,
  input  logic         dma_ack_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] rd_data_o
);
  logic sel;
  assign sel       = rd_strobe_i & dma_ack_i;
  assign rd_data_o = data_i & {W{sel}};
endmodule

// File: rtl/rx_dma_latch.sv
module rx_dma_latch
  import rx_latch_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bus_data_i,
  input  logic         bus_par_i,
  input  logic         req_i,
  input  logic         ack_i,
  input  logic         role_tgt_i,
  input  logic         dma_mode_i,
  input  logic         par_en_i,
  input  logic         dma_ack_i,
  input  logic         rd_strobe_i,
  output logic [W-1:0] rd_data_o,
  output logic         parity_err_o
);
  logic  req_rise, ack_rise, load;
  role_e role;
  logic [W-1:0] held;

  // edges detected per line before the role mux: a role flip cannot fake an edge
  hs_edge_sync #(.STAGES(STAGES)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(req_i), .rise_o(req_rise));
  hs_edge_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ack_i), .rise_o(ack_rise));

  assign role = role_e'(role_tgt_i);
  assign load = dma_mode_i & ((role == ROLE_TGT) ? ack_rise : req_rise);

  rx_capture #(.W(W), .ODD_PAR(1'b1)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .par_en_i(par_en_i),
    .data_i(bus_data_i), .par_i(bus_par_i), .data_o(held), .err_o(parity_err_o));

  rd_port #(.W(W)) u_rd (
    .rd_strobe_i(rd_strobe_i), .dma_ack_i(dma_ack_i),
    .data_i(held), .rd_data_o(rd_data_o));

  // R7
  err_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |-> $past(load));
  // R7
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |=> !parity_err_o);
endmodule

// File: tb/rx_dma_latch_bench.sv
module rx_dma_latch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = '0;
  logic       par = 1'b0, req = 1'b0, ack = 1'b0, tgt = 1'b0;
  logic       dma = 1'b0, pen = 1'b0, dack = 1'b0, ior = 1'b0;
  logic [7:0] rd;
  logic       perr;

  int checks = 0, fails = 0, err_cnt = 0;
  logic [7:0] exp_data = '0;

  always #10 clk = ~clk;

  rx_dma_latch u_rx_dma_latch (
    .clk_i(clk), .rst_ni(rst_n), .bus_data_i(data), .bus_par_i(par),
    .req_i(req), .ack_i(ack), .role_tgt_i(tgt), .dma_mode_i(dma),
    .par_en_i(pen), .dma_ack_i(dack), .rd_strobe_i(ior),
    .rd_data_o(rd), .parity_err_o(perr));

  always @(negedge clk) if (perr) err_cnt++;

  function automatic logic good_par(input logic [7:0] d);
    return ~^d;
  endfunction

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic ncyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_chk(input string req_tag);
    ior = 1'b1; dack = 1'b1; #1;
    chk(req_tag, 32'(rd), 32'(exp_data));
    ior = 1'b0; dack = 1'b0;
  endtask

  // one handshake on the chosen line; returns after the line is released
  task automatic pulse(input logic on_ack, input logic [7:0] d, input logic bad);
    @(negedge clk);
    data = d; par = good_par(d) ^ bad;
    if (on_ack) ack = 1'b1; else req = 1'b1;
    ncyc(4);
    if (on_ack) ack = 1'b0; else req = 1'b0;
    ncyc(3);
  endtask

  initial begin
    int e0;
    void'($urandom(32'h1bad_5eed));
    fork
      begin
        ncyc(190000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    join_none

    ncyc(3);
    rst_n = 1'b1;
    ncyc(2);
    // R1
    read_chk("R1");
    chk("R1", 32'(err_cnt), 0);

    // R2: target loads on ack, req ignored
    tgt = 1'b1; dma = 1'b1; pen = 1'b1;
    pulse(1'b1, 8'hA5, 1'b0); exp_data = 8'hA5; read_chk("R2");
    pulse(1'b0, 8'h3C, 1'b0); read_chk("R2");
    // R3: initiator loads on req, ack ignored
    tgt = 1'b0;
    pulse(1'b0, 8'h5A, 1'b0); exp_data = 8'h5A; read_chk("R3");
    pulse(1'b1, 8'hFF, 1'b0); read_chk("R3");
    // R4
    dma = 1'b0;
    pulse(1'b0, 8'h11, 1'b0); read_chk("R4");
    dma = 1'b1;

    // R9: latency, strobe raised before edge k, visible after k+2
    @(negedge clk);
    data = 8'hC3; par = good_par(8'hC3); req = 1'b1;
    ncyc(2);
    read_chk("R9");
    ncyc(1);
    exp_data = 8'hC3; read_chk("R9");
    // R5: held strobe, data changes, no reload
    data = 8'h99; par = good_par(8'h99);
    ncyc(5);
    read_chk("R5");
    req = 1'b0; ncyc(3);

    // R10: role flip with line high
    tgt = 1'b1;
    @(negedge clk); data = 8'h77; req = 1'b1;
    ncyc(4);
    tgt = 1'b0;
    ncyc(4);
    read_chk("R10");
    req = 1'b0; ncyc(3);

    // R6: single qualifiers give zero
    ior = 1'b1; dack = 1'b0; #1; chk("R6", 32'(rd), 0);
    ior = 1'b0; dack = 1'b1; #1; chk("R6", 32'(rd), 0);
    dack = 1'b0; #1; chk("R6", 32'(rd), 0);

    // R7 / R8 directed
    e0 = err_cnt;
    pulse(1'b0, 8'h0F, 1'b1); exp_data = 8'h0F;
    chk("R7", 32'(err_cnt - e0), 1);
    e0 = err_cnt; pen = 1'b0;
    pulse(1'b0, 8'hF1, 1'b1); exp_data = 8'hF1;
    chk("R8", 32'(err_cnt - e0), 0);
    e0 = err_cnt; pen = 1'b1; dma = 1'b0;
    pulse(1'b0, 8'h02, 1'b1);
    chk("R8", 32'(err_cnt - e0), 0);
    dma = 1'b1;
    e0 = err_cnt;
    pulse(1'b0, 8'h00, 1'b0); exp_data = 8'h00;
    chk("R8", 32'(err_cnt - e0), 0);
    read_chk("R3");

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic on_ack, bad, hit;
      logic [7:0] d;
      int e1;
      tgt = 1'($urandom); dma = ($urandom % 4) != 0; pen = 1'($urandom);
      on_ack = 1'($urandom); bad = 1'($urandom); d = 8'($urandom);
      hit = dma && (on_ack == tgt);
      e1 = err_cnt;
      pulse(on_ack, d, bad);
      if (hit) exp_data = d;
      read_chk(tgt ? "R2" : "R3");
      chk("R7", 32'(err_cnt - e1), 32'(hit && pen && bad));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule